// File: doc/BRIEF.md
# Triple-Redundant Lockstep Voter Controller

This block sits behind three identical processor cores that run the same program in lockstep. On every cycle it forms one output bus by taking a bitwise two-of-three majority of the three core buses. It also compares the copies word by word. When exactly one core departs from the other two, that core is marked as diverged and the block enters a degraded mode. In that mode the system keeps running on the voted result of the two cores that still agree.

Recovery waits for software. While degraded, the block asks for a resynchronization. It starts one only when an external permit input says that no time-critical work is in progress. During the resynchronization the output bus is parked at a fixed idle word and marked invalid. The block then waits for a completion input from the save and restore routine, and a cycle counter bounds that wait. An unrecoverable condition raises a fatal flag that only reset clears. Such a condition is no majority at all, a second divergence while degraded, or a resynchronization that never completes.

Top module: `tmr_lockstep_voter`

## Requirements
- R1: While running, `voted_bus` equals the bitwise majority `(c0&c1)|(c1&c2)|(c0&c2)` of the three core buses in the same cycle, and `voted_valid` is 1 whenever at least two cores agree.
- R2: When two cores agree and the third differs, the diverged core's bit in `core_mismatch` goes to 1 at the next clock edge and `degraded` goes to 1 there too. Bit 0 is core 0, bit 1 is core 1 and bit 2 is core 2.
- R3: In degraded mode the output stays valid and equal to the majority, which is the value of the two agreeing cores. The mismatch flag stays set even after the diverged core agrees again.
- R4: `resync_req` is 1 exactly while degraded. The block leaves degraded mode only on a clock edge at which `resync_permit` is 1. That edge makes `resync_start` 1 for exactly one cycle.
- R5: While resynchronizing, `voted_bus` equals the parameter `IDLE_WORD` and `voted_valid` is 0.
- R6: A clock edge with `resync_done` at 1 during resynchronization returns the block to lockstep. At that edge `core_mismatch` clears to 0, `degraded` is 0 and the output is voted and valid again.
- R7: If `resync_done` has not been seen within `TIMEOUT` clock edges after resynchronization began, `fatal_err` goes to 1 on edge `TIMEOUT`. It is still 0 after edge `TIMEOUT-1`.
- R8: If all three core words differ pairwise, `voted_valid` drops to 0 in the same cycle, `voted_bus` shows `IDLE_WORD`, and `fatal_err` goes to 1 at the next edge.
- R9: While degraded, a disagreement between the two cores not flagged makes `voted_valid` 0 in that cycle and sets `fatal_err` at the next edge.
- R10: Once `fatal_err` is 1 it stays 1 with `voted_valid` 0 and `voted_bus` at `IDLE_WORD` until reset, whatever the core buses do.
- R11: Synchronous active-high reset puts the block in lockstep with `core_mismatch`, `degraded`, `resync_req`, `resync_start` and `fatal_err` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core0_bus | input | DATA_W | Output bus of core 0 |
| core1_bus | input | DATA_W | Output bus of core 1 |
| core2_bus | input | DATA_W | Output bus of core 2 |
| resync_permit | input | 1 | Software allows a resynchronization to start |
| resync_done | input | 1 | Save and restore routine has finished |
| voted_bus | output | DATA_W | Majority-voted bus, or the idle word when invalid |
| voted_valid | output | 1 | Voted bus carries a trustworthy value |
| core_mismatch | output | 3 | Sticky per-core divergence flags |
| degraded | output | 1 | Running on two agreeing cores |
| resync_req | output | 1 | Resynchronization requested |
| resync_start | output | 1 | One-cycle strobe at the start of resynchronization |
| fatal_err | output | 1 | Unrecoverable error, held until reset |

## Verification
The hardest condition to reach is the second divergence. It needs a first single-core fault, then a later disagreement between exactly the two cores still trusted, with no three-way split. The bench gets there by first flagging core 0 and holding the block degraded with the permit low. It then drives equal words on cores 0 and 1 and a different word on core 2. The timeout path is reached by granting the permit and then holding the completion input low. The bench counts the edges so that it can sample both the last safe cycle and the first fatal one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCORE = 3;

    typedef enum logic [1:0] {
        ST_LOCK   = 2'd0,
        ST_DEGR   = 2'd1,
        ST_RESYNC = 2'd2,
        ST_FATAL  = 2'd3
    } tmr_state_e;

    // Pairwise equality results of the three core words.
    typedef struct packed {
        logic eq01;
        logic eq12;
        logic eq02;
    } pair_eq_t;

    function automatic logic [NCORE-1:0] single_diverged(input pair_eq_t p);
        logic [NCORE-1:0] m;
        m[0] = p.eq12 & ~p.eq01;
        m[1] = p.eq02 & ~p.eq01;
        m[2] = p.eq01 & ~p.eq02;
        return m;
    endfunction

    // The two cores not flagged disagree.
    function automatic logic trusted_split(input logic [NCORE-1:0] flag, input pair_eq_t p);
        return (flag[0] & ~p.eq12) | (flag[1] & ~p.eq02) | (flag[2] & ~p.eq01);
    endfunction

endpackage

// File: rtl/tmr_vote.sv
module tmr_vote
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  bus_in [NCORE],
    output logic [DATA_W-1:0]  maj,
    output pair_eq_t           peq,
    output logic [NCORE-1:0]   cur_mism,
    output logic               nomaj
);

    logic [NCORE-1:0] eq_v;

    // Pair k compares core k with core (k+1) mod 3.
    for (genvar k = 0; k < NCORE; k++) begin : g_pair
        assign eq_v[k] = (bus_in[k] == bus_in[(k+1) % NCORE]);
    end

    assign peq.eq01 = eq_v[0];
    assign peq.eq12 = eq_v[1];
    assign peq.eq02 = eq_v[2];

    assign maj = (bus_in[0] & bus_in[1]) | (bus_in[1] & bus_in[2]) | (bus_in[0] & bus_in[2]);

    assign cur_mism = single_diverged(peq);
    assign nomaj    = ~peq.eq01 & ~peq.eq12 & ~peq.eq02;

endmodule

// File: rtl/tmr_seq.sv
module tmr_seq
    import tmr_pkg::*;
#(
    parameter int TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  pair_eq_t          peq,
    input  logic [NCORE-1:0]  cur_mism,
    input  logic              nomaj,
    input  logic              resync_permit,
    input  logic              resync_done,
    output tmr_state_e        st,
    output logic [NCORE-1:0]  mism_q,
    output logic              fault_now,
    output logic              start_q
);

    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    always_comb begin
        fault_now = nomaj;
        if (st == ST_DEGR && trusted_split(mism_q, peq))
            fault_now = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_LOCK;
            mism_q  <= '0;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (st)
                ST_LOCK: begin
                    if (fault_now) begin
                        st <= ST_FATAL;
                    end else if (|cur_mism) begin
                        st     <= ST_DEGR;
                        mism_q <= cur_mism;
                    end
                end
                ST_DEGR: begin
                    if (fault_now) begin
                        st <= ST_FATAL;
                    end else if (resync_permit) begin
                        st      <= ST_RESYNC;
                        start_q <= 1'b1;
                        cnt_q   <= '0;
                    end
                end
                ST_RESYNC: begin
                    if (resync_done) begin
                        st     <= ST_LOCK;
                        mism_q <= '0;
                    end else if (cnt_q == LAST) begin
                        st <= ST_FATAL;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st <= ST_FATAL;
            endcase
        end
    end

    // R4: a start strobe only follows a permitted exit from degraded mode
    a_r4_start_needs_permit: assert property (@(posedge clk) disable iff (rst)
        start_q |-> ($past(resync_permit) && $past(st) == ST_DEGR));

    // R6: flags clear only on a completion edge
    a_r6_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(|mism_q) |-> $past(resync_done));

    // R7: a timeout fatal happens only after the full window
    a_r7_timeout_window: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FATAL && $past(st) == ST_RESYNC) |-> ($past(cnt_q) == LAST));

    // R10: fatal state is absorbing
    a_r10_fatal_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FATAL) |=> (st == ST_FATAL));

endmodule

// File: rtl/tmr_out.sv
module tmr_out
    import tmr_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
    input  tmr_state_e         st,
    input  logic               fault_now,
    input  logic [DATA_W-1:0]  maj,
    output logic [DATA_W-1:0]  voted_bus,
    output logic               voted_valid
);

    logic running;

    assign running     = (st == ST_LOCK) || (st == ST_DEGR);
    assign voted_valid = running && !fault_now;
    assign voted_bus   = voted_valid ? maj : IDLE_WORD;

endmodule

// File: rtl/tmr_lockstep_voter.sv
module tmr_lockstep_voter
    import tmr_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                TIMEOUT   = 4096,
    parameter logic [DATA_W-1:0] IDLE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] core0_bus,
    input  logic [DATA_W-1:0] core1_bus,
    input  logic [DATA_W-1:0] core2_bus,
    input  logic              resync_permit,
    input  logic              resync_done,
    output logic [DATA_W-1:0] voted_bus,
    output logic              voted_valid,
    output logic [2:0]        core_mismatch,
    output logic              degraded,
    output logic              resync_req,
    output logic              resync_start,
    output logic              fatal_err
);

    logic [DATA_W-1:0] bus_arr [NCORE];
    logic [DATA_W-1:0] maj;
    pair_eq_t          peq;
    logic [NCORE-1:0]  cur_mism;
    logic [NCORE-1:0]  mism_q;
    logic              nomaj;
    logic              fault_now;
    logic              start_q;
    tmr_state_e        st;

    assign bus_arr[0] = core0_bus;
    assign bus_arr[1] = core1_bus;
    assign bus_arr[2] = core2_bus;

    tmr_vote #(.DATA_W(DATA_W)) u_vote (
        .bus_in   (bus_arr),
        .maj      (maj),
        .peq      (peq),
        .cur_mism (cur_mism),
        .nomaj    (nomaj)
    );

    tmr_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .peq           (peq),
        .cur_mism      (cur_mism),
        .nomaj         (nomaj),
        .resync_permit (resync_permit),
        .resync_done   (resync_done),
        .st            (st),
        .mism_q        (mism_q),
        .fault_now     (fault_now),
        .start_q       (start_q)
    );

    tmr_out #(.DATA_W(DATA_W), .IDLE_WORD(IDLE_WORD)) u_out (
        .st          (st),
        .fault_now   (fault_now),
        .maj         (maj),
        .voted_bus   (voted_bus),
        .voted_valid (voted_valid)
    );

    assign core_mismatch = mism_q;
    assign degraded      = (st == ST_DEGR);
    assign resync_req    = (st == ST_DEGR);
    assign resync_start  = start_q;
    assign fatal_err     = (st == ST_FATAL);

    // R5: the output is never valid in the first resync cycle
    a_r5_invalid_at_start: assert property (@(posedge clk) disable iff (rst)
        resync_start |-> !voted_valid);

    // R8: a three-way split leads to the fatal flag
    a_r8_split_fatal: assert property (@(posedge clk) disable iff (rst)
        (voted_valid == 1'b0 && (st == ST_LOCK) && core0_bus != core1_bus
         && core1_bus != core2_bus && core0_bus != core2_bus) |=> fatal_err);

endmodule

// File: tb/sim_tmr_lockstep_voter.sv
module sim_tmr_lockstep_voter;

    localparam int          DW   = 16;
    localparam int          TO   = 64;
    localparam logic [15:0] IDLE = 16'hC0DE;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] c0, c1, c2;
    logic          permit, done;
    logic [DW-1:0] vbus;
    logic          vvalid, degr, req, start, fatal;
    logic [2:0]    mism;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tmr_lockstep_voter #(.DATA_W(DW), .TIMEOUT(TO), .IDLE_WORD(IDLE)) u0 (
        .clk(clk), .rst(rst),
        .core0_bus(c0), .core1_bus(c1), .core2_bus(c2),
        .resync_permit(permit), .resync_done(done),
        .voted_bus(vbus), .voted_valid(vvalid), .core_mismatch(mism),
        .degraded(degr), .resync_req(req), .resync_start(start), .fatal_err(fatal)
    );

    typedef struct packed {
        logic [15:0] a, b, c, vote;
        logic [2:0]  mm;
        logic        fat;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{16'h1234, 16'h1234, 16'h1234, 16'h1234, 3'b000, 1'b0},
        '{16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF, 3'b100, 1'b0},
        '{16'h0F0F, 16'h00FF, 16'h0F0F, 16'h0F0F, 3'b010, 1'b0},
        '{16'hAAAA, 16'h5555, 16'h5555, 16'h5555, 3'b001, 1'b0},
        '{16'h0001, 16'h0002, 16'h0004, IDLE,      3'b000, 1'b1},
        '{16'hFF00, 16'hF0F0, 16'hFF00, 16'hFF00, 3'b010, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        c0 = a; c1 = b; c2 = c;
    endtask

    task automatic do_reset();
        rst = 1'b1; permit = 1'b0; done = 1'b0;
        drive(16'h0, 16'h0, 16'h0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 mismatch", 32'(mism), 0);
        chk("R11 degraded", 32'(degr), 0);
        chk("R11 req", 32'(req), 0);
        chk("R11 start", 32'(start), 0);
        chk("R11 fatal", 32'(fatal), 0);

        // R1 R2 R8 table walk
        foreach (TBL[i]) begin
            do_reset();
            drive(TBL[i].a, TBL[i].b, TBL[i].c);
            #1;
            chk("R1 vote", 32'(vbus), 32'(TBL[i].vote));
            chk("R1/R8 valid", 32'(vvalid), 32'(!TBL[i].fat));
            @(negedge clk);
            chk("R2 mismatch", 32'(mism), 32'(TBL[i].mm));
            chk("R2 degraded", 32'(degr), 32'(TBL[i].mm != 0));
            chk("R8 fatal", 32'(fatal), 32'(TBL[i].fat));
        end

        // R3 R4 degraded running, sticky flag, permit hold-off
        do_reset();
        drive(16'h1111, 16'h2222, 16'h1111);
        @(negedge clk);
        drive(16'h3333, 16'h0000, 16'h3333);
        #1;
        chk("R3 vote", 32'(vbus), 32'h3333);
        chk("R3 valid", 32'(vvalid), 1);
        drive(16'h4444, 16'h4444, 16'h4444);
        repeat (5) @(negedge clk);
        chk("R3 sticky", 32'(mism), 32'b010);
        chk("R4 req", 32'(req), 1);
        chk("R4 no start", 32'(start), 0);
        permit = 1'b1;
        @(negedge clk);
        permit = 1'b0;
        chk("R4 start", 32'(start), 1);
        chk("R4 req off", 32'(req), 0);
        chk("R5 idle", 32'(vbus), 32'(IDLE));
        chk("R5 invalid", 32'(vvalid), 0);
        @(negedge clk);
        chk("R4 pulse", 32'(start), 0);
        repeat (20) @(negedge clk);
        chk("R5 still idle", 32'(vvalid), 0);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R6 cleared", 32'(mism), 0);
        chk("R6 degraded", 32'(degr), 0);
        chk("R6 valid", 32'(vvalid), 1);
        chk("R6 vote", 32'(vbus), 32'h4444);

        // R9 R10 second divergence and stickiness
        do_reset();
        drive(16'h0007, 16'h0005, 16'h0005);
        @(negedge clk);
        chk("R9 flagged", 32'(mism), 32'b001);
        drive(16'h0005, 16'h0005, 16'h0007);
        #1;
        chk("R9 invalid", 32'(vvalid), 0);
        @(negedge clk);
        chk("R9 fatal", 32'(fatal), 1);
        drive(16'h0009, 16'h0009, 16'h0009);
        repeat (4) @(negedge clk);
        chk("R10 fatal hold", 32'(fatal), 1);
        chk("R10 invalid", 32'(vvalid), 0);
        chk("R10 idle", 32'(vbus), 32'(IDLE));

        // R7 timeout
        do_reset();
        drive(16'h0001, 16'h0001, 16'h0003);
        @(negedge clk);
        drive(16'h0001, 16'h0001, 16'h0001);
        permit = 1'b1;
        @(negedge clk);
        permit = 1'b0;
        repeat (TO - 1) @(negedge clk);
        chk("R7 not yet", 32'(fatal), 0);
        @(negedge clk);
        chk("R7 fatal", 32'(fatal), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule